// File: doc/BRIEF.md
# Shared Mailbox Bank with Level Interrupts

This block holds a small set of single-word mailboxes that processors use to hand each other messages. Every mailbox word carries its own occupancy flag in the top bit and 31 bits of payload below it. A sender posts a message by writing the payload with the top bit set. A receiver frees the slot by writing the whole word to zero.

Each mailbox drives two level conditions: "empty" while its flag is clear and "full" while the flag is set. With the optional per-mailbox gating enabled, each condition passes only when its own enable bit is set. The gated conditions are packed into one status word, with the empty conditions in the low byte and the full conditions in the byte above. Every interrupt output has its own enable mask over that word. An output is raised, one clock later, whenever any enabled status bit is set.

Software reaches everything through a plain register port with address, write data, write enable and combinational read data. A constant register reports how many mailboxes and semaphores the instance is built with.

Top module: `smbox_array`

## Requirements
- R1: After reset every mailbox word, every per-mailbox enable and every output enable mask is zero, and every interrupt output is low.
- R2: A write to offset 0x0 of mailbox i's window (byte address 0x10000 + i*0x8000) stores all 32 bits, even if the mailbox is already full. A read of that address returns the stored word and changes no state.
- R3: Bit 31 of a mailbox word is its full flag. Writing the word to zero releases the mailbox: the flag and the payload are both cleared.
- R4: The read-only status register at 0x304 has the empty condition of mailbox i in bit i and the full condition of mailbox i in bit 8+i. Bits for mailboxes that are not built, and bits 31:16, read zero.
- R5: Interrupt output n has an enable mask at 0x100 + 4*n. Bits 15:0 are writable and read back, with the same layout as the status register. Bits 31:16 read zero.
- R6: Interrupt output n is high exactly one clock after a cycle in which the status register ANDed with mask n is nonzero. It is low one clock after that AND becomes zero.
- R7: When the gating variant is built, the window of mailbox i has a full-condition enable at offset 0x4 and an empty-condition enable at offset 0x8. Only bit 0 of each is stored and read back. A condition reaches the status register only while its enable bit is 1.
- R8: The read-only register at 0x380 returns the mailbox count in bits 3:0 and the semaphore count in bits 7:4. All other bits are zero.
- R9: Reads from unmapped addresses return zero. This covers the windows of mailboxes that are not built, unused offsets inside a window, and masks for outputs that do not exist. Writes to unmapped or read-only addresses change no status bit, mask or interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | NUM_IRQ | Level interrupt outputs, one per enable mask |

## Verification
The bench builds the block with five mailboxes, two interrupt outputs, three semaphores and the per-mailbox gating on. With this build, the windows of mailboxes 5 to 7 and the mask slot of a third output are real, decodable addresses that must read zero and must ignore writes. The gating variant also makes the status word all zero right after reset. This lets the bench show that a condition appears only once its enable is set and disappears again when the enable is cleared. With two outputs fed by different masks, the bench can watch one line rise while the other stays up and then falls, and it checks the one-clock lag on each.

// File: rtl/smbox_pkg.sv
package smbox_pkg;

  localparam int MAX_MBOX = 8;
  localparam int DATA_W   = 32;
  localparam int STAT_W   = 2 * MAX_MBOX;
  localparam int FULL_BIT = DATA_W - 1;

  // register map, byte addresses
  localparam logic [31:0] A_MASK_BASE = 32'h0000_0100;
  localparam logic [31:0] A_STATUS    = 32'h0000_0304;
  localparam logic [31:0] A_DIMENSION = 32'h0000_0380;
  localparam int          WIN_SHIFT   = 15;
  localparam int          WIN_FIRST   = 2;   // 0x10000 >> 15
  localparam logic [14:0] OFS_WORD    = 15'h0000;
  localparam logic [14:0] OFS_FULL_EN = 15'h0004;
  localparam logic [14:0] OFS_EMPT_EN = 15'h0008;

  typedef struct packed {
    logic full_req;
    logic empty_req;
  } slot_req_t;

endpackage

// File: rtl/smbox_slot.sv
module smbox_slot
  import smbox_pkg::*;
#(
  parameter bit PER_MB_IE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_word_i,
  input  logic              wr_fen_i,
  input  logic              wr_een_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] word_o,
  output logic              fen_o,
  output logic              een_o,
  output slot_req_t         req_o
);

  logic [DATA_W-1:0] word_q, word_d;
  logic              fen_q, fen_d;
  logic              een_q, een_d;

  // next state
  always_comb begin
    word_d = word_q;
    fen_d  = fen_q;
    een_d  = een_q;
    if (wr_word_i) word_d = wdata_i;
    if (wr_fen_i)  fen_d  = wdata_i[0];
    if (wr_een_i)  een_d  = wdata_i[0];
  end

  // registers with explicit clock enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      fen_q  <= 1'b0;
      een_q  <= 1'b0;
    end else begin
      if (wr_word_i) word_q <= word_d;
      if (wr_fen_i)  fen_q  <= fen_d;
      if (wr_een_i)  een_q  <= een_d;
    end
  end

  assign word_o = word_q;
  assign fen_o  = fen_q;
  assign een_o  = een_q;

  generate
    if (PER_MB_IE) begin : g_gated
      assign req_o.full_req  =  word_q[FULL_BIT] & fen_q;
      assign req_o.empty_req = ~word_q[FULL_BIT] & een_q;
    end else begin : g_ungated
      assign req_o.full_req  =  word_q[FULL_BIT];
      assign req_o.empty_req = ~word_q[FULL_BIT];
    end
  endgenerate

  p_word_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_word_i |=> word_o == $past(wdata_i));

  p_word_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_word_i |=> $stable(word_o));

  p_release_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_word_i && wdata_i == '0) |=> (!req_o.full_req && word_o == '0));

endmodule

// File: rtl/smbox_irq_agg.sv
module smbox_irq_agg
  import smbox_pkg::*;
#(
  parameter int NUM_IRQ = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STAT_W-1:0]  status_i,
  input  logic               wr_mask_i,
  input  logic [5:0]         mask_idx_i,
  input  logic [STAT_W-1:0]  wdata_i,
  output logic [STAT_W-1:0]  mask_rd_o,
  output logic [NUM_IRQ-1:0] irq_o
);

  logic [STAT_W-1:0]  mask_q [NUM_IRQ];
  logic [NUM_IRQ-1:0] irq_d, irq_q;

  generate
    for (genvar n = 0; n < NUM_IRQ; n++) begin : g_out
      logic              mask_we;
      logic [STAT_W-1:0] mask_d;

      assign mask_we  = wr_mask_i && (mask_idx_i == 6'(n));
      assign mask_d   = wdata_i;
      assign irq_d[n] = |(status_i & mask_q[n]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q[n] <= '0;
        else if (mask_we) mask_q[n] <= mask_d;
      end

      p_irq_lag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[n] == $past(|(status_i & mask_q[n])));

      p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o[n]) |-> $past(status_i != '0));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end

  always_comb begin
    mask_rd_o = '0;
    for (int n = 0; n < NUM_IRQ; n++)
      if (mask_idx_i == 6'(n)) mask_rd_o = mask_q[n];
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/smbox_array.sv
module smbox_array
  import smbox_pkg::*;
#(
  parameter int NUM_MBOX  = 8,
  parameter int NUM_IRQ   = 4,
  parameter int NUM_SEMA  = 0,
  parameter bit PER_MB_IE = 1'b1,
  parameter int ADDR_W    = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  input  logic               bus_we,
  output logic [31:0]        bus_rdata,
  output logic [NUM_IRQ-1:0] irq_o
);

  localparam int WIN_W = ADDR_W - WIN_SHIFT;
  localparam logic [WIN_W-1:0] WIN_LO = WIN_W'(WIN_FIRST);
  localparam logic [WIN_W-1:0] WIN_HI = WIN_W'(WIN_FIRST + NUM_MBOX);
  localparam logic [31:0] DIM_WORD = {24'h0, 4'(NUM_SEMA), 4'(NUM_MBOX)};

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  // address decode
  logic [WIN_W-1:0] win, mb_sel;
  logic [14:0]      wofs;
  logic             in_win, hit_word, hit_fen, hit_een;
  logic             hit_mask, hit_stat, hit_dim;

  assign win      = bus_addr[ADDR_W-1:WIN_SHIFT];
  assign wofs     = bus_addr[14:0];
  assign mb_sel   = win - WIN_LO;
  assign in_win   = (win >= WIN_LO) && (win < WIN_HI);
  assign hit_word = in_win && (wofs == OFS_WORD);
  assign hit_fen  = PER_MB_IE && in_win && (wofs == OFS_FULL_EN);
  assign hit_een  = PER_MB_IE && in_win && (wofs == OFS_EMPT_EN);
  assign hit_mask = (bus_addr[ADDR_W-1:8] == (ADDR_W-8)'(A_MASK_BASE >> 8)) &&
                    (bus_addr[1:0] == 2'b00) &&
                    (32'(bus_addr[7:2]) < NUM_IRQ);
  assign hit_stat = (bus_addr == ADDR_W'(A_STATUS));
  assign hit_dim  = (bus_addr == ADDR_W'(A_DIMENSION));

  // mailbox slots
  logic [DATA_W-1:0] word_arr [NUM_MBOX];
  logic              fen_arr  [NUM_MBOX];
  logic              een_arr  [NUM_MBOX];
  slot_req_t         req_arr  [NUM_MBOX];

  generate
    for (genvar i = 0; i < NUM_MBOX; i++) begin : g_slot
      logic mine;
      assign mine = bus_we && (mb_sel == WIN_W'(i));

      smbox_slot #(.PER_MB_IE(PER_MB_IE)) u_slot (
        .clk       (clk),
        .rst_n     (rst_s),
        .wr_word_i (mine && hit_word),
        .wr_fen_i  (mine && hit_fen),
        .wr_een_i  (mine && hit_een),
        .wdata_i   (bus_wdata),
        .word_o    (word_arr[i]),
        .fen_o     (fen_arr[i]),
        .een_o     (een_arr[i]),
        .req_o     (req_arr[i])
      );
    end
  endgenerate

  // status aggregation: empty in the low byte, full in the next
  logic [STAT_W-1:0] status_w;
  always_comb begin
    status_w = '0;
    for (int i = 0; i < NUM_MBOX; i++) begin
      status_w[i]            = req_arr[i].empty_req;
      status_w[MAX_MBOX + i] = req_arr[i].full_req;
    end
  end

  logic [STAT_W-1:0] mask_rd;
  smbox_irq_agg #(.NUM_IRQ(NUM_IRQ)) u_agg (
    .clk        (clk),
    .rst_n      (rst_s),
    .status_i   (status_w),
    .wr_mask_i  (bus_we && hit_mask),
    .mask_idx_i (bus_addr[7:2]),
    .wdata_i    (bus_wdata[STAT_W-1:0]),
    .mask_rd_o  (mask_rd),
    .irq_o      (irq_o)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (hit_stat) bus_rdata = 32'(status_w);
    if (hit_dim)  bus_rdata = DIM_WORD;
    if (hit_mask) bus_rdata = 32'(mask_rd);
    for (int i = 0; i < NUM_MBOX; i++) begin
      if (mb_sel == WIN_W'(i)) begin
        if (hit_word) bus_rdata = word_arr[i];
        if (hit_fen)  bus_rdata = {31'h0, fen_arr[i]};
        if (hit_een)  bus_rdata = {31'h0, een_arr[i]};
      end
    end
  end

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(rst_s) |-> (irq_o == '0 && status_w[STAT_W-1:MAX_MBOX] == '0));

  p_unmapped_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_s)
    !(hit_word || hit_fen || hit_een || hit_mask || hit_stat || hit_dim)
      |-> bus_rdata == '0);

  p_status_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_s)
    hit_stat |-> bus_rdata[31:STAT_W] == '0);

endmodule

// File: tb/tb_smbox_array.sv
`timescale 1ns/1ps
module tb_smbox_array;

  localparam int NMB = 5, NIRQ = 2, NSEMA = 3, AW = 20;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [AW-1:0]   bus_addr;
  logic [31:0]     bus_wdata;
  logic            bus_we;
  logic [31:0]     bus_rdata;
  logic [NIRQ-1:0] irq_o;

  always #2 clk = ~clk;   // 250 MHz

  smbox_array #(.NUM_MBOX(NMB), .NUM_IRQ(NIRQ), .NUM_SEMA(NSEMA),
                .PER_MB_IE(1'b1), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .irq_o(irq_o));

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t scb[$];
  event  chk_ev;
  int    tests = 0, fails = 0;
  bit    done  = 0;

  // scoreboard monitor
  always @(chk_ev) begin
    while (scb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = scb.pop_front();
      act = it.is_irq ? 32'(irq_o) : bus_rdata;
      tests++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  function automatic logic [AW-1:0] mba(int i, int off);
    return AW'(32'h10000 + i * 32'h8000 + off);
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic exp_rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_addr = a;
    #0.5;
    scb.push_back('{1'b0, e, tag});
    -> chk_ev;
    #0.5;
  endtask

  task automatic exp_irq(input bit next_edge, input logic [31:0] e, input string tag);
    if (next_edge) @(negedge clk);
    #0.5;
    scb.push_back('{1'b1, e, tag});
    -> chk_ev;
    #0.5;
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    exp_rd(mba(0, 0), 32'h0, "R1 mailbox word after reset");
    exp_rd(32'h100,   32'h0, "R1 mask 0 after reset");
    exp_rd(mba(2, 8), 32'h0, "R1 empty enable after reset");
    exp_rd(32'h304,   32'h0, "R1 status after reset (gated)");
    exp_irq(0, 32'h0,        "R1 irq after reset");

    exp_rd(32'h380, 32'h35, "R8 dimension word");

    // gating and status layout
    wr(mba(0, 8), 32'hFFFF_FFFF);
    exp_rd(mba(0, 8), 32'h1, "R7 empty enable keeps bit 0 only");
    exp_rd(32'h304,   32'h1, "R4 empty bit of mailbox 0");

    // mask and registered interrupt
    wr(32'h100, 32'hFFFF_FFFF);
    exp_irq(0, 32'h0,          "R6 irq not yet raised");
    exp_irq(1, 32'h1,          "R6 irq0 one clock later");
    exp_rd(32'h100, 32'hFFFF,  "R5 mask readback width");

    // post, overwrite, release
    wr(mba(0, 4), 32'h1);
    wr(mba(0, 0), 32'h8000_1234);
    exp_rd(mba(0, 0), 32'h8000_1234, "R2 posted word");
    exp_rd(32'h304,   32'h100,       "R3 full bit of mailbox 0");
    exp_irq(0, 32'h1,                "R6 irq0 held by full");
    wr(mba(0, 0), 32'h8765_4321);
    exp_rd(mba(0, 0), 32'h8765_4321, "R2 overwrite while full");
    wr(mba(0, 0), 32'h0);
    exp_rd(mba(0, 0), 32'h0,         "R3 release clears word");
    exp_rd(32'h304,   32'h1,         "R3 release returns to empty");

    // second output
    wr(32'h104, 32'h200);
    exp_rd(32'h104, 32'h200, "R5 mask 1 readback");
    wr(mba(1, 4), 32'h1);
    wr(mba(1, 0), 32'h8000_0005);
    exp_irq(0, 32'h1,        "R6 irq1 lags status");
    exp_irq(1, 32'h3,        "R6 both outputs high");
    exp_rd(32'h304, 32'h201, "R4 mixed status");
    wr(32'h100, 32'h0);
    exp_irq(1, 32'h2,        "R6 irq0 falls after mask cleared");
    wr(mba(1, 4), 32'h0);
    exp_rd(32'h304, 32'h1,   "R7 full gate removes bit 9");
    exp_irq(1, 32'h0,        "R7 irq1 falls with gate");
    exp_rd(mba(1, 4), 32'h0, "R7 full enable readback");
    exp_rd(mba(1, 0), 32'h8000_0005, "R2 read has no side effect (1)");
    exp_rd(mba(1, 0), 32'h8000_0005, "R2 read has no side effect (2)");

    // unmapped and read-only
    wr(32'h304, 32'hFFFF);
    exp_rd(32'h304, 32'h1,       "R9 status ignores writes");
    wr(32'h380, 32'h0);
    exp_rd(32'h380, 32'h35,      "R9 dimension ignores writes");
    wr(mba(5, 0), 32'h8000_0000);
    exp_rd(mba(5, 0), 32'h0,     "R9 absent mailbox reads zero");
    exp_rd(32'h304, 32'h1,       "R9 absent mailbox write ignored");
    wr(32'h108, 32'hFFFF);
    exp_rd(32'h108, 32'h0,       "R9 absent mask reads zero");
    exp_irq(1, 32'h0,            "R9 absent mask write ignored");
    exp_rd(32'h200, 32'h0,       "R9 unmapped low address");
    exp_rd(mba(0, 12), 32'h0,    "R9 unused window offset");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule